// File: doc/BRIEF.md
# Full-Speed USB Line Transmitter

This block turns a serial stream of packet bits into the levels on a full-speed USB differential pair. An upstream producer offers one bit at a time on a valid/ready handshake and marks the final bit of the packet. An external clock-enable pulses once per 12 Mbit/s bit cell. On each pulse the block drives one line symbol on the pair. It inserts a zero after every run of six ones and NRZI-encodes the result, so that a data zero flips the pair between J and K and a data one holds it.

When the packet ends, the block drives both lines low for two bit cells (the end-of-packet marker). It then drives J for one cell and releases the output-enable. A packet also ends if the producer has no bit ready when the next one is due. The sync pattern, PID, CRC, bus reset and the analog pad driver belong to other blocks.

Top module: `usb_fs_line_tx`

## Requirements
- R1: After reset, and whenever `tx_oe` is low, the pair rests at J (`tx_dp`=1, `tx_dm`=0), and `tx_oe` is low after reset.
- R2: Symbols on {`tx_dp`,`tx_dm`} are J=2'b10, K=2'b01 and SE0=2'b00. The value 2'b11 never appears.
- R3: For each accepted bit, a 0 inverts the line level of the previous cell and a 1 repeats it.
- R4: After six consecutive ones have been sent, the next cell carries an inserted zero (a level change). Any zero, sent or inserted, restarts the count of ones.
- R5: If the sixth consecutive one is the final bit of the packet, the inserted zero is still sent before the end-of-packet marker.
- R6: `bit_ready` is high only in a bit-cell cycle, while the block is idle or in the data phase and a new bit is due. It is low in the cell that carries an inserted zero and in every cell after the final bit has been taken.
- R7: After the last data or inserted cell, the block drives SE0 for two cells, then J for one cell with `tx_oe` high, then lowers `tx_oe` at the next cell.
- R8: Outputs change only at the clock edge that ends a cycle with `bit_tick` high, so each symbol lasts one whole bit cell.
- R9: If `bit_valid` is low when a data bit is due during the data phase, the packet ends: the end-of-packet marker starts in that cell.
- R10: Every packet's NRZI level starts from J, so a leading 1 is sent as J and a leading 0 as K. This holds for back-to-back packets too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per 12 MHz bit cell |
| bit_valid | input | 1 | Producer offers a bit |
| bit_data | input | 1 | Offered bit value |
| bit_final | input | 1 | Offered bit is the last of the packet |
| bit_ready | output | 1 | Offered bit is taken in this cycle |
| tx_dp | output | 1 | Positive line level |
| tx_dm | output | 1 | Negative line level |
| tx_oe | output | 1 | Pair driven when high |

## Verification
The bench builds the block with its default run length of six, two end-of-packet cells and one trailing J cell. It pulses the bit clock-enable once every three clocks, so the bench can also look at the outputs between cells. With these values an eight-bit packet reaches every stuffing position, so the bench sends all 256 eight-bit packets back to back and predicts each cell's symbol and ready level from its own NRZI and stuffing arithmetic. Directed packets then cover a run of ones that ends the packet, twelve ones in a row, a long run of zeros and a producer underrun.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

    // Line symbols as {dp, dm}
    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_K   = 2'b01,
        SYM_J   = 2'b10
    } line_sym_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_DATA = 2'b01,
        PH_EOP  = 2'b10,
        PH_TAIL = 2'b11
    } tx_phase_e;

    // level: 1 = J, 0 = K
    function automatic line_sym_e level_to_sym(input logic level);
        return level ? SYM_J : SYM_K;
    endfunction

endpackage

// File: rtl/usbtx_stuff_ctr.sv
module usbtx_stuff_ctr #(
    parameter int RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic restart,
    input  logic one,
    output logic due
);
    localparam int CW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] ones;
    } ctr_t;

    ctr_t cur_q, nxt_d;
    logic [CW-1:0] base;

    always_comb begin
        nxt_d = cur_q;
        base  = restart ? '0 : cur_q.ones;
        if (step) begin
            nxt_d.ones = one ? base + CW'(1) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign due = (cur_q.ones == CW'(RUN_LEN));

endmodule

// File: rtl/usbtx_nrzi.sv
module usbtx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic restart,
    input  logic toggle,
    output logic level_d
);
    logic level_q;
    logic level_nxt;

    always_comb begin
        level_d   = (restart ? 1'b1 : level_q) ^ toggle;
        level_nxt = step ? level_d : level_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b1;
        else        level_q <= level_nxt;
    end

endmodule

// File: rtl/usbtx_line_reg.sv
module usbtx_line_reg
    import usbtx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  line_sym_e sym_in,
    input  logic      oe_in,
    output logic      dp,
    output logic      dm,
    output logic      oe
);
    typedef struct packed {
        line_sym_e sym;
        logic      oe;
    } line_t;

    line_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.oe  = oe_in;
            nxt_d.sym = oe_in ? sym_in : SYM_J;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{sym: SYM_J, oe: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign dp = cur_q.sym[1];
    assign dm = cur_q.sym[0];
    assign oe = cur_q.oe;

endmodule

// File: rtl/usb_fs_line_tx.sv
module usb_fs_line_tx
    import usbtx_pkg::*;
#(
    parameter int RUN_LEN    = 6,
    parameter int EOP_CELLS  = 2,
    parameter int TAIL_CELLS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic bit_valid,
    input  logic bit_data,
    input  logic bit_final,
    output logic bit_ready,
    output logic tx_dp,
    output logic tx_dm,
    output logic tx_oe
);
    localparam int MAXC = (EOP_CELLS > TAIL_CELLS) ? EOP_CELLS : TAIL_CELLS;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] EOP_LAST  = CW'(EOP_CELLS - 1);
    localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_CELLS - 1);

    typedef struct packed {
        tx_phase_e     ph;
        logic [CW-1:0] cnt;
        logic          final_sent;
    } seq_t;

    seq_t      cur_q, nxt_d;
    logic      stuff_due;
    logic      lvl_d;
    logic      nz_step, nz_restart, nz_toggle;
    logic      sc_step, sc_one;
    logic      ld;
    line_sym_e sym;
    logic      oe_nxt;

    always_comb begin
        nxt_d      = cur_q;
        nz_step    = 1'b0;
        nz_restart = 1'b0;
        nz_toggle  = 1'b0;
        sc_step    = 1'b0;
        sc_one     = 1'b0;
        ld         = 1'b0;
        sym        = SYM_J;
        oe_nxt     = 1'b0;
        bit_ready  = bit_tick && ((cur_q.ph == PH_IDLE) ||
                     (cur_q.ph == PH_DATA && !stuff_due && !cur_q.final_sent));
        if (bit_tick) begin
            unique case (cur_q.ph)
                PH_IDLE: begin
                    if (bit_valid) begin
                        ld               = 1'b1;
                        oe_nxt           = 1'b1;
                        nz_restart       = 1'b1;
                        nz_step          = 1'b1;
                        nz_toggle        = ~bit_data;
                        sc_step          = 1'b1;
                        sc_one           = bit_data;
                        sym              = level_to_sym(lvl_d);
                        nxt_d.ph         = PH_DATA;
                        nxt_d.final_sent = bit_final;
                    end
                end
                PH_DATA: begin
                    ld     = 1'b1;
                    oe_nxt = 1'b1;
                    if (stuff_due) begin
                        nz_step   = 1'b1;
                        nz_toggle = 1'b1;
                        sc_step   = 1'b1;
                        sc_one    = 1'b0;
                        sym       = level_to_sym(lvl_d);
                    end else if (cur_q.final_sent || !bit_valid) begin
                        sym       = SYM_SE0;
                        nxt_d.ph  = PH_EOP;
                        nxt_d.cnt = '0;
                    end else begin
                        nz_step          = 1'b1;
                        nz_toggle        = ~bit_data;
                        sc_step          = 1'b1;
                        sc_one           = bit_data;
                        sym              = level_to_sym(lvl_d);
                        nxt_d.final_sent = bit_final;
                    end
                end
                PH_EOP: begin
                    ld     = 1'b1;
                    oe_nxt = 1'b1;
                    if (cur_q.cnt == EOP_LAST) begin
                        sym       = SYM_J;
                        nxt_d.ph  = PH_TAIL;
                        nxt_d.cnt = '0;
                    end else begin
                        sym       = SYM_SE0;
                        nxt_d.cnt = cur_q.cnt + CW'(1);
                    end
                end
                PH_TAIL: begin
                    ld  = 1'b1;
                    sym = SYM_J;
                    if (cur_q.cnt == TAIL_LAST) begin
                        oe_nxt           = 1'b0;
                        nxt_d.ph         = PH_IDLE;
                        nxt_d.final_sent = 1'b0;
                    end else begin
                        oe_nxt    = 1'b1;
                        nxt_d.cnt = cur_q.cnt + CW'(1);
                    end
                end
                default: nxt_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{ph: PH_IDLE, cnt: '0, final_sent: 1'b0};
        else        cur_q <= nxt_d;
    end

    usbtx_stuff_ctr #(.RUN_LEN(RUN_LEN)) u_stuff (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (sc_step),
        .restart (nz_restart),
        .one     (sc_one),
        .due     (stuff_due)
    );

    usbtx_nrzi u_nrzi (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (nz_step),
        .restart (nz_restart),
        .toggle  (nz_toggle),
        .level_d (lvl_d)
    );

    usbtx_line_reg u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ld),
        .sym_in (sym),
        .oe_in  (oe_nxt),
        .dp     (tx_dp),
        .dm     (tx_dm),
        .oe     (tx_oe)
    );

endmodule

// File: rtl/usbtx_checker.sv
module usbtx_checker #(
    parameter int RUN_LEN = 6
) (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic bit_ready,
    input logic tx_dp,
    input logic tx_dm,
    input logic tx_oe
);
    logic       tick_d1;
    logic       prev_ok;
    logic [1:0] prev_sym;
    logic [7:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_d1  <= 1'b0;
            prev_ok  <= 1'b0;
            prev_sym <= 2'b10;
            run      <= '0;
        end else begin
            tick_d1 <= bit_tick;
            if (tick_d1) begin
                if (tx_oe && {tx_dp, tx_dm} != 2'b00) begin
                    run      <= (prev_ok && prev_sym == {tx_dp, tx_dm}) ? run + 8'd1 : 8'd0;
                    prev_sym <= {tx_dp, tx_dm};
                    prev_ok  <= 1'b1;
                end else begin
                    prev_ok <= 1'b0;
                    run     <= '0;
                end
            end
        end
    end

    AST_IDLE_AT_J: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> (tx_dp && !tx_dm)); // R1
    AST_NO_SE1: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dp && tx_dm)); // R2
    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run <= 8'(RUN_LEN)); // R4
    AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ready |-> bit_tick); // R6
    AST_TAIL_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_oe) |-> $past(tx_dp && !tx_dm)); // R7
    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable({tx_dp, tx_dm, tx_oe})); // R8

endmodule

bind usb_fs_line_tx usbtx_checker #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .bit_ready (bit_ready),
    .tx_dp     (tx_dp),
    .tx_dm     (tx_dm),
    .tx_oe     (tx_oe)
);

// File: tb/usb_fs_line_tx_bench.sv
module usb_fs_line_tx_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_data = 1'b0;
    logic bit_final = 1'b0;
    logic bit_ready, tx_dp, tx_dm, tx_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usb_fs_line_tx u_usb_fs_line_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bit_valid(bit_valid),
        .bit_data(bit_data), .bit_final(bit_final), .bit_ready(bit_ready),
        .tx_dp(tx_dp), .tx_dm(tx_dm), .tx_oe(tx_oe)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Sends bits[0..n-1]; bit_valid drops once index reaches stop.
    task automatic run_packet(input logic [31:0] bits, input int n, input int stop);
        logic lvl = 1'b1;
        int ones = 0;
        int idx = 0;
        int phase = 0;
        int ecnt = 0;
        logic er;
        logic [1:0] es;
        logic eo;
        string tag;
        while (phase != 3) begin
            @(negedge clk);
            bit_tick  = 1'b1;
            bit_valid = (phase == 0) && (idx < stop);
            bit_data  = (idx < 32) ? bits[idx] : 1'b0;
            bit_final = (idx == n - 1);
            eo = 1'b1;
            if (phase == 0) begin
                if (ones == 6) begin
                    lvl = ~lvl; ones = 0; er = 1'b0;
                    es = {lvl, ~lvl};
                    tag = (idx == n) ? "R5 stuffed after final one" : "R4 stuffed zero";
                end else if (idx >= stop) begin
                    er = (idx < n); es = 2'b00; phase = 1; ecnt = 1;
                    tag = (idx < n) ? "R9 underrun starts EOP" : "R7 first SE0";
                end else begin
                    er = 1'b1;
                    if (!bits[idx]) lvl = ~lvl;
                    ones = bits[idx] ? ones + 1 : 0;
                    es = {lvl, ~lvl};
                    tag = (idx == 0) ? "R10 first cell from J" : "R3 NRZI data cell";
                    idx++;
                end
            end else if (phase == 1) begin
                er = 1'b0;
                if (ecnt < 2) begin es = 2'b00; ecnt++; tag = "R7 second SE0"; end
                else begin es = 2'b10; phase = 2; tag = "R7 trailing J"; end
            end else begin
                er = 1'b0; es = 2'b10; eo = 1'b0; phase = 3;
                tag = "R7 release to idle J R1";
            end
            #1;
            check("R6 ready", {2'b00, bit_ready}, {2'b00, er});
            @(negedge clk);
            bit_tick = 1'b0; bit_valid = 1'b0;
            check(tag, {tx_dp, tx_dm, tx_oe}, {es, eo});
            check("R2 no 11 symbol", {1'b0, tx_dp & tx_dm}, 3'b000);
            @(negedge clk);
            check("R8 held between ticks", {tx_dp, tx_dm, tx_oe}, {es, eo});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset idle J", {tx_dp, tx_dm, tx_oe}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        bit_tick = 1'b1; #1;
        check("R1 ready in idle", {2'b00, bit_ready}, 3'b001);
        @(negedge clk);
        bit_tick = 1'b0;
        check("R1 no valid stays idle", {tx_dp, tx_dm, tx_oe}, 3'b100);
        for (int p = 0; p < 256; p++) run_packet(32'(p), 8, 8);
        run_packet(32'h0000_003F, 6, 6);   // R5: six ones, the last is final
        run_packet(32'h0000_007F, 7, 7);   // R4: stuff then a final one
        run_packet(32'h0000_0FFF, 12, 12); // R4: two stuffs in one packet
        run_packet(32'h0000_0000, 20, 20); // R3: long zero run
        run_packet(32'h0000_03FF, 10, 4);  // R9: producer underrun
        run_packet(32'h0000_0001, 1, 1);   // R10: single-bit packet
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule